// File: doc/BRIEF.md
# One-Level Section Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a single descriptor from a table in memory. Each table entry is one 32-bit word and covers one 1MB section of the address space. A requester presents a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The walker computes where the descriptor lives from a table base value, fetches that word over a simple valid/ready read port, and then judges the descriptor. It checks the descriptor type, then the owning domain's code in a 16-entry domain control word, then execute-never, then the access-permission bits. It answers with either a physical address and its memory attributes, or a fault code.

Only one walk is in flight at a time. A new request is refused until the current answer has been taken. When translation is switched off, the address passes straight through one cycle after acceptance and no memory read is made.

Top module: `section_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: With translation on, exactly one descriptor read is issued per request, at address ttb OR (va[31:20] << 2). mem_req_addr stays stable while mem_req_valid waits for mem_req_ready, and the descriptor may return any number of cycles later.
- R3: A valid section descriptor has bits[1:0]=2'b10 and bit 18 clear. If no fault arises, rsp_pa is {descriptor[31:20], va[19:0]} and rsp_fault is 0.
- R4: Any other descriptor encoding (bits[1:0] not 2'b10, or bit 18 set) gives rsp_fault=1 (translation).
- R5: The domain number is descriptor[8:5] and its code is dacr[2d+1:2d]. Code 2'b00 (no access) and 2'b10 (reserved) give rsp_fault=2 (domain).
- R6: Under code 2'b01 (client), the permission bits AP2=bit 15 and AP=bits[11:10] are checked; a refused access gives rsp_fault=3. Reads and fetches are allowed when AP is not 00 and (priv=1 or AP[1]=1). Writes are allowed only when AP2=0 and (AP=11, or priv=1 and AP is not 00). Under code 2'b11 (manager), the permission bits are not checked.
- R7: When descriptor bit 4 (execute-never) is set, a fetch (req_kind=2'b10) gives rsp_fault=4. Reads and writes are unaffected. The XN check applies under both client and manager codes.
- R8: Fault priority: translation over domain over execute-never over permission.
- R9: On success, rsp_mtype is 0 for TEX=bits[14:12]=000 with C=bit 3=0 and B=bit 2=0 (strongly ordered), 1 for TEX=001 with C=B=1 (normal write-back write-allocate), and 2 otherwise. rsp_shared is bit 16, rsp_global is the inverse of bit 17, rsp_ns is bit 19, and rsp_impl is bit 9.
- R10: With xlat_en=0 at acceptance, rsp_valid rises on the next cycle with rsp_pa equal to the request address, rsp_fault=0, all attribute outputs 0, and no memory read.
- R11: req_ready is low from acceptance until the response handshake completes. rsp_valid and its payload hold steady until rsp_ready.
- R12: On any fault, rsp_pa carries the faulting virtual address, and rsp_mtype, rsp_shared, rsp_global, rsp_ns and rsp_impl are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable; 0 passes addresses through |
| ttb | input | 32 | Translation table base |
| dacr | input | 32 | Domain control word, 2 bits per domain |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_priv | input | 1 | Privileged access |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 32 | Physical address, or faulting VA |
| rsp_fault | output | 3 | 0 none, 1 translation, 2 domain, 3 permission, 4 execute-never |
| rsp_mtype | output | 2 | Memory type code |
| rsp_shared | output | 1 | Shareable attribute |
| rsp_global | output | 1 | Global (not address-space tagged) |
| rsp_ns | output | 1 | Non-secure attribute |
| rsp_impl | output | 1 | Implementation-defined descriptor bit |

## Verification
The assertions assume that ttb and dacr stay constant while a walk is in flight. They also assume that mem_rsp_valid pulses only once per accepted read, after that read's handshake. The bench sets ttb and dacr once, before reset is released, and never changes them. Its memory model raises mem_rsp_valid for exactly one cycle, and only after it has granted the matching request. Request and ready signals are changed shortly after a rising edge, so each handshake is seen cleanly on the next edge.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_XLAT   = 3'd1,
        FLT_DOMAIN = 3'd2,
        FLT_PERM   = 3'd3,
        FLT_XN     = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        MT_STRONG = 2'd0,
        MT_NORMAL = 2'd1,
        MT_OTHER  = 2'd2
    } mtype_e;

    typedef enum logic [1:0] {
        DC_NOACC   = 2'b00,
        DC_CLIENT  = 2'b01,
        DC_RSVD    = 2'b10,
        DC_MANAGER = 2'b11
    } dom_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;

    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;
    localparam logic [1:0] TYPE_SECT  = 2'b10;

endpackage

// File: rtl/sw_check.sv
module sw_check
    import sw_pkg::*;
#(
    parameter int DOM_CNT = 16,
    localparam int DOM_W  = $clog2(DOM_CNT),
    localparam int DACR_W = 2 * DOM_CNT
) (
    input  logic [1:0]        dtype,
    input  logic              ssect,
    input  logic [DOM_W-1:0]  dom,
    input  logic              xn,
    input  logic              ap2,
    input  logic [1:0]        ap,
    input  logic [DACR_W-1:0] dacr,
    input  logic [1:0]        kind,
    input  logic              priv,
    output fault_e            fault
);

    logic [1:0] dom_code [DOM_CNT];

    genvar g;
    generate
        for (g = 0; g < DOM_CNT; g++) begin : g_dom
            assign dom_code[g] = dacr[2*g +: 2];
        end
    endgenerate

    logic [1:0] code;
    logic       rd_ok;
    logic       wr_ok;
    logic       perm_ok;

    always_comb begin
        code    = dom_code[dom];
        rd_ok   = (ap != 2'b00) && (priv || ap[1]);
        wr_ok   = !ap2 && ((ap == 2'b11) || (priv && (ap != 2'b00)));
        perm_ok = (kind == KIND_WRITE) ? wr_ok : rd_ok;

        if ((dtype != TYPE_SECT) || ssect) begin
            fault = FLT_XLAT;
        end else if ((code == DC_NOACC) || (code == DC_RSVD)) begin
            fault = FLT_DOMAIN;
        end else if (xn && (kind == KIND_FETCH)) begin
            fault = FLT_XN;
        end else if ((code == DC_CLIENT) && !perm_ok) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/sw_attr.sv
module sw_attr
    import sw_pkg::*;
(
    input  logic [2:0] tex,
    input  logic       cbit,
    input  logic       bbit,
    output mtype_e     mtype
);

    always_comb begin
        case ({tex, cbit, bbit})
            5'b000_0_0: mtype = MT_STRONG;
            5'b001_1_1: mtype = MT_NORMAL;
            default:    mtype = MT_OTHER;
        endcase
    end

endmodule

// File: rtl/section_walker.sv
module section_walker
    import sw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SECT_W  = 20,
    parameter int DOM_CNT = 16,
    localparam int DACR_W = 2 * DOM_CNT,
    localparam int IDX_W  = ADDR_W - SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] ttb,
    input  logic [DACR_W-1:0] dacr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic [2:0]        rsp_fault,
    output logic [1:0]        rsp_mtype,
    output logic              rsp_shared,
    output logic              rsp_global,
    output logic              rsp_ns,
    output logic              rsp_impl
);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic [1:0]        kind;
        logic              priv;
        logic [ADDR_W-1:0] maddr;
        logic [ADDR_W-1:0] pa;
        fault_e            fault;
        mtype_e            mtype;
        logic              shared;
        logic              glob;
        logic              ns;
        logic              impl;
    } walk_t;

    walk_t r_q, r_d;

    fault_e chk_fault;
    mtype_e chk_mtype;

    sw_check #(.DOM_CNT(DOM_CNT)) check_i (
        .dtype (mem_rsp_data[1:0]),
        .ssect (mem_rsp_data[18]),
        .dom   (mem_rsp_data[8:5]),
        .xn    (mem_rsp_data[4]),
        .ap2   (mem_rsp_data[15]),
        .ap    (mem_rsp_data[11:10]),
        .dacr  (dacr),
        .kind  (r_q.kind),
        .priv  (r_q.priv),
        .fault (chk_fault)
    );

    sw_attr attr_i (
        .tex   (mem_rsp_data[14:12]),
        .cbit  (mem_rsp_data[3]),
        .bbit  (mem_rsp_data[2]),
        .mtype (chk_mtype)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_va;
                    r_d.kind = req_kind;
                    r_d.priv = req_priv;
                    if (!xlat_en) begin
                        r_d.pa     = req_va;
                        r_d.fault  = FLT_NONE;
                        r_d.mtype  = MT_STRONG;
                        r_d.shared = 1'b0;
                        r_d.glob   = 1'b0;
                        r_d.ns     = 1'b0;
                        r_d.impl   = 1'b0;
                        r_d.st     = ST_RESP;
                    end else begin
                        r_d.maddr = ttb | (ADDR_W'(req_va[ADDR_W-1:SECT_W]) << 2);
                        r_d.st    = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.fault = chk_fault;
                    if (chk_fault == FLT_NONE) begin
                        r_d.pa     = {mem_rsp_data[ADDR_W-1:SECT_W], r_q.va[SECT_W-1:0]};
                        r_d.mtype  = chk_mtype;
                        r_d.shared = mem_rsp_data[16];
                        r_d.glob   = !mem_rsp_data[17];
                        r_d.ns     = mem_rsp_data[19];
                        r_d.impl   = mem_rsp_data[9];
                    end else begin
                        r_d.pa     = r_q.va;
                        r_d.mtype  = MT_STRONG;
                        r_d.shared = 1'b0;
                        r_d.glob   = 1'b0;
                        r_d.ns     = 1'b0;
                        r_d.impl   = 1'b0;
                    end
                    r_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, fault: FLT_NONE, mtype: MT_STRONG, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_FETCH);
    assign mem_req_addr  = r_q.maddr;
    assign rsp_valid     = (r_q.st == ST_RESP);
    assign rsp_pa        = r_q.pa;
    assign rsp_fault     = r_q.fault;
    assign rsp_mtype     = r_q.mtype;
    assign rsp_shared    = r_q.shared;
    assign rsp_global    = r_q.glob;
    assign rsp_ns        = r_q.ns;
    assign rsp_impl      = r_q.impl;

    // R2: descriptor read request held steady until granted
    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: a non-section descriptor always ends in a translation fault
    assert_bad_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WAIT) && mem_rsp_valid && (mem_rsp_data[1:0] != 2'b10))
        |=> (rsp_valid && (rsp_fault == 3'd1)));

    // R10: pass-through answers next cycle with the request address
    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en)
        |=> (rsp_valid && (rsp_pa == $past(req_va)) && (rsp_fault == 3'd0) && !mem_req_valid));

    // R11: no second acceptance right after one
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: result held until taken
    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
        |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_mtype)));

    // R12: faults carry no attributes
    assert_fault_attr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != 3'd0))
        |-> ((rsp_mtype == 2'd0) && !rsp_shared && !rsp_global && !rsp_ns && !rsp_impl));

endmodule

// File: tb/section_walker_tb_top.sv
`timescale 1ns/1ps
module section_walker_tb_top;

    localparam logic [31:0] TTB  = 32'h3070_0000;
    localparam logic [31:0] DACR = 32'h5555_558D; // d0 client, d1 manager, d2 none, d3 reserved

    typedef struct {
        logic [31:0] pa;
        logic [2:0]  fault;
        logic [1:0]  mtype;
        logic        shared;
        logic        glob;
        logic        ns;
        logic        impl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [1:0]  rsp_mtype;
    logic        rsp_shared, rsp_global, rsp_ns, rsp_impl;

    int total = 0;
    int bad = 0;
    int exp_reads = 0;
    int got_reads = 0;
    bit done = 1'b0;

    exp_t        sb_q[$];
    logic [31:0] addr_q[$];
    logic [31:0] tbl [int];

    always #2 clk = ~clk;

    section_walker dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .ttb(TTB), .dacr(DACR),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_kind(req_kind), .req_priv(req_priv),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_mtype(rsp_mtype),
        .rsp_shared(rsp_shared), .rsp_global(rsp_global), .rsp_ns(rsp_ns),
        .rsp_impl(rsp_impl)
    );

    function automatic logic [31:0] mk(input logic [11:0] base, input logic ap2,
        input logic [1:0] ap, input logic [3:0] dom, input logic xn, input logic [2:0] tex,
        input logic c, input logic b, input logic s, input logic ng, input logic ns,
        input logic impl, input logic [1:0] typ);
        return {base, ns, 1'b0, ng, s, ap2, tex, ap, impl, dom, xn, c, b, typ};
    endfunction

    function automatic logic [31:0] lookup(input logic [11:0] idx);
        return tbl.exists(int'(idx)) ? tbl[int'(idx)] : 32'h0;
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
        input logic priv, input logic en, input string tag);
        exp_t e;
        logic [31:0] d;
        logic [1:0] code;
        logic ok;
        logic wr;
        e = '{pa: va, fault: 3'd0, mtype: 2'd0, shared: 1'b0, glob: 1'b0,
              ns: 1'b0, impl: 1'b0, tag: tag};
        if (!en) return e;
        d = lookup(va[31:20]);
        code = DACR[{d[8:5], 1'b0} +: 2];
        wr = (kind == 2'b01);
        if (d[1:0] != 2'b10 || d[18]) begin e.fault = 3'd1; return e; end
        if (code == 2'b00 || code == 2'b10) begin e.fault = 3'd2; return e; end
        if (d[4] && kind == 2'b10) begin e.fault = 3'd4; return e; end
        if (code == 2'b01) begin
            case ({d[15], d[11:10]})
                3'b000: ok = 1'b0;
                3'b001: ok = priv;
                3'b010: ok = priv || !wr;
                3'b011: ok = 1'b1;
                3'b100: ok = 1'b0;
                3'b101: ok = priv && !wr;
                default: ok = !wr;
            endcase
            if (!ok) begin e.fault = 3'd3; return e; end
        end
        e.pa = {d[31:20], va[19:0]};
        if (d[14:12] == 3'b000 && d[3:2] == 2'b00) e.mtype = 2'd0;
        else if (d[14:12] == 3'b001 && d[3:2] == 2'b11) e.mtype = 2'd1;
        else e.mtype = 2'd2;
        e.shared = d[16];
        e.glob = !d[17];
        e.ns = d[19];
        e.impl = d[9];
        return e;
    endfunction

    task automatic check(input bit cond, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] va, input logic [1:0] kind, input logic priv,
                        input logic en, input string tag);
        exp_t e;
        e = model(va, kind, priv, en, tag);
        sb_q.push_back(e);
        if (en) begin
            exp_reads++;
            addr_q.push_back(TTB | ({20'h0, va[31:20]} << 2));
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = va; req_kind = kind; req_priv = priv; xlat_en = en;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!en) begin
            @(negedge clk);
            check(rsp_valid == 1'b1, "R10 next-cycle valid", 64'(rsp_valid), 64'd1);
        end
    endtask

    // rsp_ready pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            rsp_ready = ($urandom % 4) != 0;
        end
    end

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] want;
                logic [31:0] a;
                a = mem_req_addr;
                got_reads++;
                want = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
                check(a == want, "R2 descriptor address", 64'(a), 64'(want));
                repeat ($urandom % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                @(posedge clk); #1;
                mem_req_ready = 1'b0;
                repeat ($urandom % 5) @(posedge clk);
                #1;
                mem_rsp_valid = 1'b1;
                mem_rsp_data = lookup(a[13:2]);
                @(posedge clk); #1;
                mem_rsp_valid = 1'b0;
                mem_rsp_data = '0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid && rsp_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected response", 64'(rsp_pa), 64'd0);
                end else begin
                    exp_t e;
                    logic [38:0] act, exv;
                    e = sb_q.pop_front();
                    act = {rsp_pa, rsp_fault, rsp_mtype, rsp_shared, rsp_global, rsp_ns};
                    exv = {e.pa, e.fault, e.mtype, e.shared, e.glob, e.ns};
                    check(act == exv && rsp_impl == e.impl, e.tag, 64'(act), 64'(exv));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tbl[32'hC80] = mk(12'h3F0, 0, 2'b11, 4'd15, 1, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'hC82] = mk(12'h3F2, 0, 2'b11, 4'd15, 1, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h000] = mk(12'h000, 0, 2'b11, 4'd0, 0, 3'b001, 1, 1, 1, 0, 0, 0, 2'b10);
        tbl[32'h001] = mk(12'h101, 0, 2'b01, 4'd0, 0, 3'b000, 0, 0, 0, 1, 1, 1, 2'b10);
        tbl[32'h002] = mk(12'h202, 1, 2'b01, 4'd0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h003] = mk(12'h303, 1, 2'b11, 4'd0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h004] = mk(12'h404, 0, 2'b00, 4'd1, 0, 3'b000, 1, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h005] = mk(12'h505, 0, 2'b11, 4'd2, 1, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h006] = mk(12'h606, 0, 2'b11, 4'd3, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h007] = mk(12'h707, 0, 2'b11, 4'd0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b01);
        tbl[32'h009] = mk(12'h909, 0, 2'b11, 4'd2, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b11);
        tbl[32'h00A] = mk(12'hA0A, 0, 2'b00, 4'd1, 1, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h00B] = mk(12'hB0B, 0, 2'b00, 4'd0, 1, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10);
        tbl[32'h00C] = mk(12'hC0C, 0, 2'b11, 4'd0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b10)
                       | 32'h0004_0000; // bit 18 set

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        send(32'hC821_5040, 2'b01, 1'b0, 1'b1, "R3 mapped write");
        send(32'hC800_0004, 2'b00, 1'b1, 1'b1, "R3 mapped read");
        send(32'hC821_5054, 2'b10, 1'b1, 1'b1, "R7 xn fetch");
        send(32'h0001_2340, 2'b10, 1'b0, 1'b1, "R9 normal fetch attrs");
        send(32'h001F_FFFC, 2'b00, 1'b0, 1'b1, "R6 user read priv-only");
        send(32'h0010_0000, 2'b01, 1'b1, 1'b1, "R9 priv write ok ng ns impl");
        send(32'h0020_0010, 2'b01, 1'b1, 1'b1, "R6 write to read-only");
        send(32'h0020_0010, 2'b00, 1'b1, 1'b1, "R6 priv read ro");
        send(32'h0020_0010, 2'b00, 1'b0, 1'b1, "R6 user read priv-ro");
        send(32'h0030_0100, 2'b00, 1'b0, 1'b1, "R6 user read ro");
        send(32'h0030_0100, 2'b01, 1'b0, 1'b1, "R6 user write ro");
        send(32'h0040_0020, 2'b01, 1'b0, 1'b1, "R6 manager skips ap");
        send(32'h0050_0000, 2'b10, 1'b1, 1'b1, "R5 R8 no-access before xn");
        send(32'h0060_0000, 2'b00, 1'b1, 1'b1, "R5 reserved code");
        send(32'h0070_0000, 2'b00, 1'b1, 1'b1, "R4 page-table type");
        send(32'h0080_0000, 2'b00, 1'b1, 1'b1, "R4 empty entry");
        send(32'h0090_0000, 2'b00, 1'b1, 1'b1, "R4 R8 type before domain");
        send(32'h00C0_0000, 2'b00, 1'b1, 1'b1, "R4 bit18 set");
        send(32'h00A0_0000, 2'b10, 1'b0, 1'b1, "R7 xn under manager");
        send(32'h00B0_0000, 2'b10, 1'b0, 1'b1, "R8 xn before permission");
        send(32'h00B0_0000, 2'b00, 1'b0, 1'b1, "R12 perm fault pa=va");
        send(32'hC821_5040, 2'b01, 1'b0, 1'b0, "R10 bypass");
        send(32'h1234_5678, 2'b10, 1'b0, 1'b0, "R10 bypass fetch");
        for (int i = 0; i < 20; i++) begin
            send({12'hC80 + 12'(2 * (i % 2)), 20'(i * 32'h1357)}, 2'(i % 3), 1'(i % 2),
                 1'((i % 5) != 0), "R11 back-to-back mix");
        end

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(got_reads == exp_reads, "R2 R10 read count", 64'(got_reads), 64'(exp_reads));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule